// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the byte that steers the system clock. Software uses it to choose between the main clock and the PLL clock, to pick a main-clock divide ratio, to request stop mode and to set the oscillator drive strength. Every write passes through protection rules first. A write counts only while the global protect-enable input is 1. Lock flags from other registers then keep specific bits from changing, and one hardware rule forces the drive-strength bit high when stop mode is entered.

The outputs are a clock-enable pulse train derived from the main clock (`clk`), a registered source-select flag, and a stop request flag. The PLL source is reported only once the PLL reports ready. A new divide ratio is loaded only at the end of the current divide period, so the enable train never produces a shortened or stretched period. Writes travel through the register every cycle. The asynchronous reset is synchronised on release.

Top module: `sysclk_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x20, `src_pll` and `stop_req` are 0, and `clk_en` is 1 in every cycle.
- R2: When `wr_en` is 1 and `prot_en` is 0, nothing is written and `rd_data` stays unchanged.
- R3: An accepted write (`wr_en` and `prot_en` both 1) has this layout: bits 7:6 are the divider code, bit 5 is drive strength, bit 1 is PLL select and bit 0 is stop. Bits 4:2 always read 0. The new value is visible on `rd_data` in the cycle after the write.
- R4: While `clkmod_lock` is 1, an accepted write leaves bits 1 and 0 unchanged and updates bits 7:5.
- R5: While `wdt_lock` is 1, an accepted write leaves bit 0 unchanged. Bit 1 and bits 7:5 still update, subject to R4.
- R6: A write that would change bit 0 from 0 to 1 is discarded for bit 0 alone when the stored bit 1 is 1 or when `osc_det_en` is 1. A write of 0 to bit 0 is allowed.
- R7: When bit 0 changes from 0 to 1, bit 5 becomes 1 whatever value was written to it. `stop_req` always equals bit 0.
- R8: `src_pll` is 1 in a cycle exactly when, in the previous cycle, the stored bit 1 and `pll_ready` were both 1.
- R9: With `div_override` at 0, the divider codes 00, 01, 10 and 11 give a `clk_en` pulse every 1, 2, 4 and 16 cycles. With `div_override` at 1, `clk_en` is high in every cycle.
- R10: A change of divider code takes effect only after the `clk_en` pulse that ends the current period. The period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| prot_en | input | 1 | Global write-protect enable (1 allows writes) |
| clkmod_lock | input | 1 | Clock-modification lock (freezes bits 1 and 0) |
| wdt_lock | input | 1 | Watchdog-on-internal-oscillator lock (freezes bit 0) |
| osc_det_en | input | 1 | Oscillation-stop detection enabled (blocks setting stop) |
| div_override | input | 1 | Divider override (1 forces divide by 1) |
| pll_ready | input | 1 | PLL locked and usable |
| rd_data | output | 8 | Register readback |
| clk_en | output | 1 | Divided clock enable |
| src_pll | output | 1 | 1 selects the PLL clock, 0 selects the main clock |
| stop_req | output | 1 | Stop mode request |

## Verification
The properties assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that the lock and detection flags are plain levels, which the stimulus provides by driving all inputs on the falling edge. The random phase biases `prot_en` and the lock flags so that accepted, rejected and partly locked writes all occur often, and it keeps `div_override` at 0 so that divider timing is exercised only by the directed period measurements. The stop-blocking properties take the stored PLL-select bit as the reference. The bench model uses the same reference.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [1:0] {
    DIV_1  = 2'b00,
    DIV_2  = 2'b01,
    DIV_4  = 2'b10,
    DIV_16 = 2'b11
  } div_code_e;

  typedef struct packed {
    div_code_e  div;
    logic       drive;
    logic [2:0] rsvd;
    logic       pll_sel;
    logic       stop;
  } ctrl_reg_t;

  localparam ctrl_reg_t CTRL_RST = '{div: DIV_1, drive: 1'b1, rsvd: 3'b000,
                                     pll_sel: 1'b0, stop: 1'b0};

  // log2 of the divide ratio for each code
  function automatic int unsigned div_shift(div_code_e code);
    case (code)
      DIV_1:   return 0;
      DIV_2:   return 1;
      DIV_4:   return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/sysclk_rst_sync.sv
module sysclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/sysclk_reg_core.sv
module sysclk_reg_core
  import sysclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      prot_en,
  input  logic [7:0] wr_data,
  input  logic      clkmod_lock,
  input  logic      wdt_lock,
  input  logic      osc_det_en,
  output ctrl_reg_t reg_q
);
  ctrl_reg_t reg_d;
  logic      accept;
  logic      stop_wr_ok;
  logic      stop_set_blocked;
  logic      unused_rsvd;

  assign accept           = wr_en & prot_en;
  assign stop_wr_ok       = ~clkmod_lock & ~wdt_lock;
  assign stop_set_blocked = reg_q.pll_sel | osc_det_en;
  assign unused_rsvd      = ^wr_data[4:2];

  always_comb begin
    reg_d = reg_q;
    if (accept) begin
      reg_d.div   = div_code_e'(wr_data[7:6]);
      reg_d.drive = wr_data[5];
      reg_d.rsvd  = 3'b000;
      if (!clkmod_lock) reg_d.pll_sel = wr_data[1];
      if (stop_wr_ok) begin
        if (wr_data[0] && !reg_q.stop) begin
          if (!stop_set_blocked) reg_d.stop = 1'b1;
        end else begin
          reg_d.stop = wr_data[0];
        end
      end
      if (reg_d.stop && !reg_q.stop) reg_d.drive = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= CTRL_RST;
    else        reg_q <= reg_d;
  end
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
  import sysclk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  div_code_e code,
  input  logic      bypass,
  output logic      clk_en
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] load;

  always_comb begin
    span = (CNT_W+1)'(1) << div_shift(code);
    load = bypass ? '0 : CNT_W'(span - (CNT_W+1)'(1));
  end

  assign clk_en = (cnt_q == '0);

  always_comb begin
    if (clk_en) cnt_d = load;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sysclk_src_sel.sv
module sysclk_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_sel,
  input  logic pll_ready,
  output logic src_pll
);
  logic src_d;

  assign src_d = pll_sel & pll_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_pll <= 1'b0;
    else        src_pll <= src_d;
  end
endmodule

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       prot_en,
  input  logic       clkmod_lock,
  input  logic       wdt_lock,
  input  logic       osc_det_en,
  input  logic       div_override,
  input  logic       pll_ready,
  output logic [7:0] rd_data,
  output logic       clk_en,
  output logic       src_pll,
  output logic       stop_req
);
  localparam int MAX_DIV = 1 << div_shift(DIV_16);
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic      rst_ns;
  ctrl_reg_t reg_q;

  sysclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_ns)
  );

  sysclk_reg_core u_core (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .prot_en(prot_en),
    .wr_data(wr_data), .clkmod_lock(clkmod_lock), .wdt_lock(wdt_lock),
    .osc_det_en(osc_det_en), .reg_q(reg_q)
  );

  sysclk_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_ns), .code(reg_q.div), .bypass(div_override),
    .clk_en(clk_en)
  );

  sysclk_src_sel u_src (
    .clk(clk), .rst_n(rst_ns), .pll_sel(reg_q.pll_sel),
    .pll_ready(pll_ready), .src_pll(src_pll)
  );

  assign rd_data  = reg_q;
  assign stop_req = reg_q.stop;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       prot_en,
  input logic       clkmod_lock,
  input logic       wdt_lock,
  input logic       osc_det_en,
  input logic       div_override,
  input logic       pll_ready,
  input logic [7:0] rd_data,
  input logic       clk_en,
  input logic       src_pll,
  input logic       stop_req
);
  // R2
  unprotected_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && prot_en) |=> $stable(rd_data));

  // R3
  reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:2] == 3'b000);

  // R4
  clkmod_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkmod_lock |=> rd_data[1:0] == $past(rd_data[1:0]));

  // R5
  wdt_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_lock |=> rd_data[0] == $past(rd_data[0]));

  // R6
  stop_set_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] && (rd_data[1] || osc_det_en)) |=> !rd_data[0]);

  // R7
  stop_forces_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> rd_data[5]);

  // R8
  pll_source_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pll |-> $past(rd_data[1] && pll_ready));

  // R9
  override_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && div_override) |=> clk_en);
endmodule

bind sysclk_ctrl_reg sysclk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .prot_en(prot_en),
  .clkmod_lock(clkmod_lock), .wdt_lock(wdt_lock), .osc_det_en(osc_det_en),
  .div_override(div_override), .pll_ready(pll_ready), .rd_data(rd_data),
  .clk_en(clk_en), .src_pll(src_pll), .stop_req(stop_req)
);

// File: tb/sysclk_ctrl_reg_bench.sv
`timescale 1ns/1ps
module sysclk_ctrl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, prot_en, clkmod_lock, wdt_lock, osc_det_en;
  logic       div_override, pll_ready;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       clk_en, src_pll, stop_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [7:0] m_reg;
  logic       m_src;

  always #2 clk = ~clk;

  sysclk_ctrl_reg u_sysclk_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .prot_en(prot_en), .clkmod_lock(clkmod_lock), .wdt_lock(wdt_lock),
    .osc_det_en(osc_det_en), .div_override(div_override),
    .pll_ready(pll_ready), .rd_data(rd_data), .clk_en(clk_en),
    .src_pll(src_pll), .stop_req(stop_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_next(logic [7:0] cur, bit we, bit pe,
      logic [7:0] d, bit cl, bit wl, bit od);
    logic [7:0] n;
    n = cur;
    if (we && pe) begin
      n[7:5] = d[7:5];
      n[4:2] = 3'b000;
      if (!cl) n[1] = d[1];
      if (!cl && !wl) begin
        if (d[0] && !cur[0]) n[0] = !(cur[1] || od);
        else                 n[0] = d[0];
      end
      if (n[0] && !cur[0]) n[5] = 1'b1;
    end
    return n;
  endfunction

  // called at a falling edge; applies inputs for one rising edge, checks at next fall
  task automatic step(input bit we, input logic [7:0] d, input bit pe, input bit cl,
      input bit wl, input bit od, input bit pr, input string tag);
    wr_en = we; wr_data = d; prot_en = pe; clkmod_lock = cl;
    wdt_lock = wl; osc_det_en = od; pll_ready = pr;
    m_src = m_reg[1] & pr;
    m_reg = model_next(m_reg, we, pe, d, cl, wl, od);
    @(negedge clk);
    wr_en = 1'b0;
    chk(tag, rd_data, m_reg);
    chk("R8 src_pll", src_pll, m_src);
    chk("R7 stop_req", stop_req, m_reg[0]);
  endtask

  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clk_en);
  endtask

  task automatic check_period(input logic [1:0] code, input int exp, input string tag);
    int g;
    step(1'b1, {code, 6'b100000}, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    count_to_pulse(g);
    count_to_pulse(g);
    chk(tag, g, exp);
    count_to_pulse(g);
    chk(tag, g, exp);
  endtask

  initial begin
    int g;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; prot_en = 1'b0;
    clkmod_lock = 1'b0; wdt_lock = 1'b0; osc_det_en = 1'b0;
    div_override = 1'b0; pll_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_reg = 8'h20; m_src = 1'b0;

    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h20);
    chk("R1 src_pll", src_pll, 1'b0);
    chk("R1 stop_req", stop_req, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 clk_en", clk_en, 1'b1);
      @(negedge clk);
    end

    step(1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 protected write");
    step(1'b1, 8'hDE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 layout");
    chk("R3 reserved", rd_data[4:2], 3'b000);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 not ready");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 ready");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 ready held");
    chk("R8 src on", src_pll, 1'b1);
    step(1'b1, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6 pll blocks stop");
    chk("R6 stop blocked", rd_data[0], 1'b0);
    step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6 osc det blocks stop");
    step(1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 stop forces drive");
    chk("R7 drive", rd_data, 8'h21);
    step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 stop clear");
    step(1'b1, 8'hE3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 clock lock");
    chk("R4 value", rd_data, 8'hE0);
    step(1'b1, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 watchdog lock");
    chk("R5 value", rd_data, 8'hC2);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 8'($urandom), ($urandom % 5) != 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, "R3 random write");
    end

    step(1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 clear");
    check_period(2'b00, 1, "R9 div1");
    check_period(2'b01, 2, "R9 div2");
    check_period(2'b10, 4, "R9 div4");
    check_period(2'b11, 16, "R9 div16");
    div_override = 1'b1;
    count_to_pulse(g);
    count_to_pulse(g);
    chk("R9 override", g, 1);
    count_to_pulse(g);
    chk("R9 override", g, 1);
    div_override = 1'b0;
    count_to_pulse(g);
    count_to_pulse(g);
    chk("R9 override off", g, 16);

    // R10 mid-period change keeps current period length
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 idle");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 idle");
    step(1'b1, 8'h60, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 write div2");
    count_to_pulse(g);
    chk("R10 old period", g + 3, 16);
    count_to_pulse(g);
    chk("R10 new period", g, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule